// File: doc/BRIEF.md
# DMA Control Byte Sequencer

This block sits between a processor's single byte-wide control port and the parameter registers of a DMA controller. When nothing is pending, each written byte is decoded as a base selector. The high bit and the two low bits classify the byte. Its flag bits then decide which parameter bytes the processor is expected to send next. Those expected destinations are kept as an ordered pending queue. Each later write lands in the destination at the head of the queue, until the queue runs dry and decoding of base bytes resumes.

One destination can extend the queue while it is being written. The interrupt control byte appends a pulse-control slot and an interrupt-vector slot behind whatever is still pending. Bytes in the command class are not decoded here. They are handed on to a separate command executor through a one-cycle strobe. The block also forms a registered "working" qualifier from the stored state, the end-of-block flag, the match flag and the device ready line. When working rises it emits a one-cycle start pulse for the transfer engine.

Top module: `dmaseq_top`

## Requirements
- R1: Every accepted write clears the DMA enable output. The only exception is a base byte of class 3 (bit7=1, bits1:0=00), which loads enable from its bit6. dma_en reads 0 after reset.
- R2: With the queue empty, a byte with bit7=0 and bits1:0 not 00 is stored as base_r0. Its bits 3, 4, 5 and 6 each queue one slot, in this order: port-A address low, port-A address high, length low, length high. Each following write fills the next slot.
- R3: With the queue empty, a byte with bit7=0 and bits1:0=00 is a port setup byte. It is stored in port_a_cfg when bit2=1 and in port_b_cfg when bit2=0. If its bit6 is set, it queues one timing byte, which is accepted and changes no output.
- R4: With the queue empty, a byte with bit7=1 and bits1:0=00 sets int_en from bit5 and dma_en from bit6. Its bit3 queues a mask_byte slot, and then its bit4 queues a match_byte slot.
- R5: With the queue empty, a byte with bit7=1 and bits1:0=01 is accepted only if bits6:5 are not 11. When accepted, it is stored as base_r4 and xfer_mode takes bits6:5. Bits 2, 3 and 4 then queue port-B address low, port-B address high and int_ctrl, in that order. A rejected byte changes no register and queues nothing.
- R6: With the queue empty, a byte with bit7=1 and bits1:0=10 is stored as base_r5 only when its bits 6 and 2 are both 0. A byte with bit7=1 and bits1:0=11 changes no register. It raises cmd_stb for one cycle, with cmd_byte holding that byte.
- R7: A write into the int_ctrl slot appends slots behind the rest of the queue. Its bit3 appends a pulse_ctrl slot, and then its bit4 appends an int_vector slot.
- R8: working is 1 exactly when all of these hold: dma_en is 1; base_r0 bits1:0 are not 00; eob_flag is 0; match_flag is 0 or base_r0 bit1 is 0; and either xfer_mode is 1 or the ready condition is true. working lags these inputs by one clock.
- R9: The ready condition is base_r5 bit3 XOR an internal level bit. That bit resets to 1 and is loaded with the inverse of dev_ready on every clock.
- R10: start_pulse is high for exactly the first cycle in which working is 1 after having been 0.
- R11: The pending queue holds QDEPTH slots (default 8). A base byte restarts it from slot zero. Once its last slot is written, the next write is decoded as a base byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-port write strobe |
| wr_data | input | 8 | Control-port write byte |
| dev_ready | input | 1 | Device ready line |
| eob_flag | input | 1 | End-of-block flag from the transfer engine |
| match_flag | input | 1 | Match flag from the transfer engine |
| base_r0 | output | 8 | Stored class-0 base byte |
| port_a_cfg | output | 8 | Port A setup byte |
| port_b_cfg | output | 8 | Port B setup byte |
| mask_byte | output | 8 | Search mask |
| match_byte | output | 8 | Search match value |
| int_en | output | 1 | Interrupt enable |
| dma_en | output | 1 | DMA enable |
| base_r4 | output | 8 | Stored class-4 base byte |
| xfer_mode | output | 2 | Transfer mode |
| base_r5 | output | 8 | Stored class-5 base byte |
| addr_a | output | 16 | Port A start address |
| addr_b | output | 16 | Port B start address |
| blk_len | output | 16 | Block length |
| int_ctrl | output | 8 | Interrupt control byte |
| pulse_ctrl | output | 8 | Pulse control byte |
| int_vector | output | 8 | Interrupt vector |
| cmd_stb | output | 1 | One-cycle strobe for a command byte |
| cmd_byte | output | 8 | Last command byte |
| working | output | 1 | Registered run qualifier |
| start_pulse | output | 1 | One-cycle pulse on a rise of working |

## Verification
The bench builds the block with the default queue depth of 8. At that depth the deepest chain fits: a class-4 byte queues three slots, and the int_ctrl byte appends two more. The bench sweeps all 256 base byte values from reset. After each one it feeds exactly the parameter bytes its own model expects, with int_ctrl values that always trigger both appends. So every classification, every rejection rule and every queue ordering is reached. Directed sequences then toggle the end-of-block flag, the match flag, the ready line and the mode. They check the working qualifier, the ready level and the start pulse.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  localparam int unsigned DEST_W   = 4;
  localparam int unsigned MAX_LOAD = 4;
  localparam int unsigned LOAD_CW  = $clog2(MAX_LOAD + 1);

  typedef enum logic [DEST_W-1:0] {
    DST_NONE, DST_A_LO, DST_A_HI, DST_LEN_LO, DST_LEN_HI, DST_TIMING,
    DST_MASK, DST_MATCH, DST_B_LO, DST_B_HI, DST_INTCTL, DST_PULSE, DST_VECTOR
  } dest_e;

  typedef enum logic [2:0] {
    BK_R0, BK_PCFG, BK_R3, BK_R4, BK_R5, BK_CMD, BK_DROP
  } base_kind_e;
endpackage

// File: rtl/dmaseq_base_decode.sv
module dmaseq_base_decode
  import dmaseq_pkg::*;
(
  input  logic [7:0]                         byte_i,
  output base_kind_e                         kind_o,
  output logic [MAX_LOAD-1:0][DEST_W-1:0]    list_o,
  output logic [LOAD_CW-1:0]                 n_o
);
  logic [MAX_LOAD-1:0][DEST_W-1:0] cand;
  logic [MAX_LOAD-1:0]             cand_v;
  logic [1:0]                      wp;

  // classify the byte and list candidate slots in their fixed order
  always_comb begin
    kind_o = BK_DROP;
    cand   = '0;
    cand_v = '0;
    if (!byte_i[7]) begin
      if (byte_i[1:0] != 2'b00) begin
        kind_o  = BK_R0;
        cand[0] = DST_A_LO;
        cand[1] = DST_A_HI;
        cand[2] = DST_LEN_LO;
        cand[3] = DST_LEN_HI;
        cand_v  = byte_i[6:3];
      end else begin
        kind_o    = BK_PCFG;
        cand[0]   = DST_TIMING;
        cand_v[0] = byte_i[6];
      end
    end else begin
      case (byte_i[1:0])
        2'b00: begin
          kind_o    = BK_R3;
          cand[0]   = DST_MASK;
          cand[1]   = DST_MATCH;
          cand_v[0] = byte_i[3];
          cand_v[1] = byte_i[4];
        end
        2'b01: begin
          if (byte_i[6:5] != 2'b11) begin
            kind_o    = BK_R4;
            cand[0]   = DST_B_LO;
            cand[1]   = DST_B_HI;
            cand[2]   = DST_INTCTL;
            cand_v[0] = byte_i[2];
            cand_v[1] = byte_i[3];
            cand_v[2] = byte_i[4];
          end
        end
        2'b10: begin
          if (!byte_i[6] && !byte_i[2]) kind_o = BK_R5;
        end
        default: kind_o = BK_CMD;
      endcase
    end
  end

  // compact the valid candidates to the front, keeping their order
  always_comb begin
    list_o = '0;
    n_o    = '0;
    wp     = '0;
    for (int s = 0; s < MAX_LOAD; s++) begin
      if (cand_v[s]) begin
        list_o[wp] = cand[s];
        wp         = wp + 2'd1;
        n_o        = n_o + LOAD_CW'(1);
      end
    end
  end
endmodule

// File: rtl/dmaseq_pend_queue.sv
module dmaseq_pend_queue
  import dmaseq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load_i,
  input  logic [MAX_LOAD-1:0][DEST_W-1:0] load_list_i,
  input  logic [LOAD_CW-1:0]              load_n_i,
  input  logic                            pop_i,
  input  logic [1:0]                      app_n_i,
  input  logic [1:0][DEST_W-1:0]          app_list_i,
  output logic                            busy_o,
  output logic [DEST_W-1:0]               head_o
);
  logic [DEST_W-1:0] mem [DEPTH];
  logic [IW-1:0]     rd_ptr;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     tail;

  assign tail   = IW'(rd_ptr + cnt);
  assign busy_o = (cnt != '0);
  assign head_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (load_i) begin
      rd_ptr <= '0;
      cnt    <= CW'(load_n_i);
    end else if (pop_i) begin
      rd_ptr <= rd_ptr + IW'(1);
      cnt    <= cnt - CW'(1) + CW'(app_n_i);
    end
  end

  // slot storage, no reset
  always_ff @(posedge clk) begin
    if (load_i) begin
      for (int i = 0; i < MAX_LOAD; i++) begin
        if (i < int'(load_n_i)) mem[IW'(i)] <= load_list_i[i];
      end
    end else if (pop_i) begin
      for (int j = 0; j < 2; j++) begin
        if (j < int'(app_n_i)) mem[tail + IW'(j)] <= app_list_i[j];
      end
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (int'(rd_ptr) + int'(cnt) + int'(app_n_i) <= int'(DEPTH)));

  // R11
  pop_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> busy_o);

  // R11
  load_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !busy_o);
endmodule

// File: rtl/dmaseq_run_qual.sv
module dmaseq_run_qual (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [1:0] r0_lo_i,
  input  logic       eob_i,
  input  logic       match_i,
  input  logic [1:0] mode_i,
  input  logic       rdy_pol_i,
  input  logic       dev_ready_i,
  output logic       working_o,
  output logic       start_o
);
  logic rdy_lvl_q;
  logic run_c;

  always_comb begin
    run_c = en_i && (r0_lo_i != 2'b00) && !eob_i && !(r0_lo_i[1] && match_i)
            && ((mode_i == 2'd1) || (rdy_pol_i ^ rdy_lvl_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_lvl_q <= 1'b1;
      working_o <= 1'b0;
      start_o   <= 1'b0;
    end else begin
      rdy_lvl_q <= ~dev_ready_i;
      working_o <= run_c;
      start_o   <= run_c & ~working_o;
    end
  end

  // R10
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R10
  start_with_work_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> working_o);

  // R8
  work_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    working_o |-> $past(en_i) && !$past(eob_i));
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int unsigned QDEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        dev_ready,
  input  logic        eob_flag,
  input  logic        match_flag,
  output logic [7:0]  base_r0,
  output logic [7:0]  port_a_cfg,
  output logic [7:0]  port_b_cfg,
  output logic [7:0]  mask_byte,
  output logic [7:0]  match_byte,
  output logic        int_en,
  output logic        dma_en,
  output logic [7:0]  base_r4,
  output logic [1:0]  xfer_mode,
  output logic [7:0]  base_r5,
  output logic [15:0] addr_a,
  output logic [15:0] addr_b,
  output logic [15:0] blk_len,
  output logic [7:0]  int_ctrl,
  output logic [7:0]  pulse_ctrl,
  output logic [7:0]  int_vector,
  output logic        cmd_stb,
  output logic [7:0]  cmd_byte,
  output logic        working,
  output logic        start_pulse
);
  base_kind_e                      dec_kind;
  logic [MAX_LOAD-1:0][DEST_W-1:0] dec_list;
  logic [LOAD_CW-1:0]              dec_n;
  logic                            busy;
  logic [DEST_W-1:0]               head;
  logic                            take_base;
  logic                            take_param;
  logic [1:0]                      app_n;
  logic [1:0][DEST_W-1:0]          app_list;

  dmaseq_base_decode u_dec (
    .byte_i (wr_data),
    .kind_o (dec_kind),
    .list_o (dec_list),
    .n_o    (dec_n)
  );

  assign take_base  = wr_en && !busy;
  assign take_param = wr_en && busy;

  // int_ctrl slot extends the queue: pulse first, then vector
  always_comb begin
    app_n    = '0;
    app_list = '0;
    if (take_param && (dest_e'(head) == DST_INTCTL)) begin
      if (wr_data[3] && wr_data[4]) begin
        app_list[0] = DST_PULSE;
        app_list[1] = DST_VECTOR;
        app_n       = 2'd2;
      end else if (wr_data[3]) begin
        app_list[0] = DST_PULSE;
        app_n       = 2'd1;
      end else if (wr_data[4]) begin
        app_list[0] = DST_VECTOR;
        app_n       = 2'd1;
      end
    end
  end

  dmaseq_pend_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk         (clk),
    .rst         (rst),
    .load_i      (take_base),
    .load_list_i (dec_list),
    .load_n_i    (dec_n),
    .pop_i       (take_param),
    .app_n_i     (app_n),
    .app_list_i  (app_list),
    .busy_o      (busy),
    .head_o      (head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_r0    <= '0;
      port_a_cfg <= '0;
      port_b_cfg <= '0;
      mask_byte  <= '0;
      match_byte <= '0;
      int_en     <= 1'b0;
      dma_en     <= 1'b0;
      base_r4    <= '0;
      xfer_mode  <= '0;
      base_r5    <= '0;
      addr_a     <= '0;
      addr_b     <= '0;
      blk_len    <= '0;
      int_ctrl   <= '0;
      pulse_ctrl <= '0;
      int_vector <= '0;
      cmd_stb    <= 1'b0;
      cmd_byte   <= '0;
    end else begin
      cmd_stb <= 1'b0;
      if (wr_en) dma_en <= 1'b0;
      if (take_base) begin
        case (dec_kind)
          BK_R0:   base_r0 <= wr_data;
          BK_PCFG: begin
            if (wr_data[2]) port_a_cfg <= wr_data;
            else            port_b_cfg <= wr_data;
          end
          BK_R3: begin
            int_en <= wr_data[5];
            dma_en <= wr_data[6];
          end
          BK_R4: begin
            base_r4   <= wr_data;
            xfer_mode <= wr_data[6:5];
          end
          BK_R5:   base_r5 <= wr_data;
          BK_CMD: begin
            cmd_stb  <= 1'b1;
            cmd_byte <= wr_data;
          end
          default: ;
        endcase
      end
      if (take_param) begin
        case (dest_e'(head))
          DST_A_LO:   addr_a[7:0]   <= wr_data;
          DST_A_HI:   addr_a[15:8]  <= wr_data;
          DST_LEN_LO: blk_len[7:0]  <= wr_data;
          DST_LEN_HI: blk_len[15:8] <= wr_data;
          DST_MASK:   mask_byte     <= wr_data;
          DST_MATCH:  match_byte    <= wr_data;
          DST_B_LO:   addr_b[7:0]   <= wr_data;
          DST_B_HI:   addr_b[15:8]  <= wr_data;
          DST_INTCTL: int_ctrl      <= wr_data;
          DST_PULSE:  pulse_ctrl    <= wr_data;
          DST_VECTOR: int_vector    <= wr_data;
          default: ;
        endcase
      end
    end
  end

  dmaseq_run_qual u_run (
    .clk         (clk),
    .rst         (rst),
    .en_i        (dma_en),
    .r0_lo_i     (base_r0[1:0]),
    .eob_i       (eob_flag),
    .match_i     (match_flag),
    .mode_i      (xfer_mode),
    .rdy_pol_i   (base_r5[3]),
    .dev_ready_i (dev_ready),
    .working_o   (working),
    .start_o     (start_pulse)
  );

  // R1
  en_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (busy || (dec_kind != BK_R3))) |=> !dma_en);

  // R6
  cmd_source_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> $past(wr_en) && ($past(wr_data) == cmd_byte) && (cmd_byte[1:0] == 2'b11));

  // R5
  mode_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(xfer_mode) |-> $past(wr_en) && ($past(wr_data[1:0]) == 2'b01) && $past(wr_data[7]));

  // R4
  int_en_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(int_en) |-> $past(wr_en) && ($past(wr_data[1:0]) == 2'b00) && $past(wr_data[7]));
endmodule

// File: tb/tb_dmaseq_top.sv
module tb_dmaseq_top;
  localparam int QD_NONE = 0, QD_ALO = 1, QD_AHI = 2, QD_LLO = 3, QD_LHI = 4,
                 QD_TIM = 5, QD_MASK = 6, QD_MATCH = 7, QD_BLO = 8, QD_BHI = 9,
                 QD_INTC = 10, QD_PULSE = 11, QD_VEC = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic dev_ready = 1'b1, eob_flag = 1'b0, match_flag = 1'b0;
  logic [7:0] base_r0, port_a_cfg, port_b_cfg, mask_byte, match_byte, base_r4, base_r5;
  logic [7:0] int_ctrl, pulse_ctrl, int_vector, cmd_byte;
  logic [15:0] addr_a, addr_b, blk_len;
  logic [1:0] xfer_mode;
  logic int_en, dma_en, cmd_stb, working, start_pulse;

  int errors = 0, checks = 0;
  int q [16];
  int qn, qp;
  logic [7:0] e_r0, e_ca, e_cb, e_mask, e_match, e_r4, e_r5, e_ic, e_pc, e_iv;
  logic [15:0] e_aa, e_ab, e_len;
  logic [1:0] e_mode;
  logic e_inten, e_en, e_cmd;

  // 10-unit period: 100 MHz at 1 ns units
  always #5 clk = ~clk;

  dmaseq_top #(.QDEPTH(8)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .dev_ready(dev_ready),
    .eob_flag(eob_flag), .match_flag(match_flag), .base_r0(base_r0),
    .port_a_cfg(port_a_cfg), .port_b_cfg(port_b_cfg), .mask_byte(mask_byte),
    .match_byte(match_byte), .int_en(int_en), .dma_en(dma_en), .base_r4(base_r4),
    .xfer_mode(xfer_mode), .base_r5(base_r5), .addr_a(addr_a), .addr_b(addr_b),
    .blk_len(blk_len), .int_ctrl(int_ctrl), .pulse_ctrl(pulse_ctrl),
    .int_vector(int_vector), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
    .working(working), .start_pulse(start_pulse)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input int d);
    q[qn] = d;
    qn++;
  endtask

  task automatic model_clear();
    {e_r0, e_ca, e_cb, e_mask, e_match, e_r4, e_r5, e_ic, e_pc, e_iv} = '0;
    {e_aa, e_ab, e_len} = '0;
    e_mode = '0; e_inten = 1'b0; e_en = 1'b0; e_cmd = 1'b0;
    qn = 0; qp = 0;
  endtask

  task automatic model_base(input logic [7:0] v);
    e_en = 1'b0;
    if (!v[7]) begin
      if (v[1:0] != 2'b00) begin
        e_r0 = v;
        if (v[3]) push(QD_ALO);
        if (v[4]) push(QD_AHI);
        if (v[5]) push(QD_LLO);
        if (v[6]) push(QD_LHI);
      end else begin
        if (v[2]) e_ca = v; else e_cb = v;
        if (v[6]) push(QD_TIM);
      end
    end else begin
      case (v[1:0])
        2'b00: begin
          e_inten = v[5]; e_en = v[6];
          if (v[3]) push(QD_MASK);
          if (v[4]) push(QD_MATCH);
        end
        2'b01: if (v[6:5] != 2'b11) begin
          e_r4 = v; e_mode = v[6:5];
          if (v[2]) push(QD_BLO);
          if (v[3]) push(QD_BHI);
          if (v[4]) push(QD_INTC);
        end
        2'b10: if (!v[6] && !v[2]) e_r5 = v;
        default: e_cmd = 1'b1;
      endcase
    end
  endtask

  task automatic model_param(input int d, input logic [7:0] v);
    e_en = 1'b0;
    case (d)
      QD_ALO: e_aa[7:0] = v;
      QD_AHI: e_aa[15:8] = v;
      QD_LLO: e_len[7:0] = v;
      QD_LHI: e_len[15:8] = v;
      QD_MASK: e_mask = v;
      QD_MATCH: e_match = v;
      QD_BLO: e_ab[7:0] = v;
      QD_BHI: e_ab[15:8] = v;
      QD_INTC: begin
        e_ic = v;
        if (v[3]) push(QD_PULSE);
        if (v[4]) push(QD_VEC);
      end
      QD_PULSE: e_pc = v;
      QD_VEC: e_iv = v;
      default: ;
    endcase
  endtask

  task automatic compare_all();
    chk(dma_en, e_en, "R1", "dma_en");
    chk({base_r0, addr_a, blk_len}, {e_r0, e_aa, e_len}, "R2", "r0/addr_a/len");
    chk({port_a_cfg, port_b_cfg}, {e_ca, e_cb}, "R3", "port cfg");
    chk({mask_byte, match_byte, 7'd0, int_en}, {e_mask, e_match, 7'd0, e_inten}, "R4", "mask/match/int_en");
    chk({base_r4, 6'd0, xfer_mode, addr_b, int_ctrl}, {e_r4, 6'd0, e_mode, e_ab, e_ic}, "R5", "r4/mode/addr_b/int_ctrl");
    chk(base_r5, e_r5, "R6", "base_r5");
    chk({pulse_ctrl, int_vector}, {e_pc, e_iv}, "R7", "pulse/vector");
  endtask

  // drains the queue from the model: R11 ends when the model's queue is empty
  task automatic sweep_one(input logic [7:0] v);
    logic [7:0] d;
    do_reset();
    model_clear();
    model_base(v);
    write_byte(v);
    chk({7'd0, cmd_stb, cmd_byte}, {7'd0, e_cmd, e_cmd ? v : 8'h00}, "R6", "cmd strobe");
    while (qp < qn) begin
      d = 8'h18 + 8'(qp);
      write_byte(d);
      model_param(q[qp], d);
      qp++;
    end
    compare_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    do_reset();
    // reset state
    chk({dma_en, int_en, working, start_pulse, cmd_stb}, 5'b0, "R1", "reset flags");
    chk({base_r0, base_r4, base_r5, xfer_mode}, 26'd0, "R8", "reset regs");

    for (int v = 0; v < 256; v++) sweep_one(8'(v));

    // R11: queue drains, next byte is decoded as a base byte
    do_reset();
    write_byte(8'h09);
    write_byte(8'h55);
    write_byte(8'h03);
    chk({base_r0, addr_a[7:0]}, {8'h03, 8'h55}, "R11", "drain then base");

    // R7: int_ctrl with neither append bit leaves the queue empty
    do_reset();
    write_byte(8'h91);
    write_byte(8'h00);
    write_byte(8'h01);
    chk({base_r0, pulse_ctrl, int_ctrl}, {8'h01, 8'h00, 8'h00}, "R7", "no append");

    // working qualifier
    do_reset();
    write_byte(8'h01);
    write_byte(8'h8A);
    write_byte(8'hC0);
    chk(dma_en, 1'b1, "R4", "enable loaded");
    step(1);
    chk({working, start_pulse}, 2'b11, "R10", "rise with start");
    step(1);
    chk({working, start_pulse}, 2'b10, "R10", "start one cycle");
    eob_flag = 1'b1;
    step(1);
    chk(working, 1'b0, "R8", "eob blocks");
    eob_flag = 1'b0;
    step(1);
    chk({working, start_pulse}, 2'b11, "R10", "restart after eob");
    dev_ready = 1'b0;
    step(2);
    chk(working, 1'b0, "R9", "not ready");
    dev_ready = 1'b1;
    step(2);
    chk(working, 1'b1, "R9", "ready again");
    match_flag = 1'b1;
    step(1);
    chk(working, 1'b1, "R8", "match ignored bit1=0");
    write_byte(8'h02);
    chk(dma_en, 1'b0, "R1", "write clears enable");
    write_byte(8'hC0);
    step(1);
    chk(working, 1'b0, "R8", "match blocks bit1=1");
    match_flag = 1'b0;
    step(1);
    chk(working, 1'b1, "R8", "match cleared");
    dev_ready = 1'b0;
    step(2);
    chk(working, 1'b0, "R9", "mode0 needs ready");
    write_byte(8'hA1);
    write_byte(8'hC0);
    step(1);
    chk({6'd0, xfer_mode, working}, {6'd0, 2'd1, 1'b1}, "R8", "mode1 ignores ready");
    write_byte(8'h8A);
    chk(dma_en, 1'b0, "R1", "reg5 write clears enable");
    step(1);
    chk(working, 1'b0, "R8", "no enable no work");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule